// File: doc/BRIEF.md
# Sequential Booth Signed Multiplier

This block multiplies two N-bit two's-complement numbers over several clock cycles and returns the full 2N-bit signed product. N is a parameter and defaults to 32. A single request pulse on `start` loads both operands while the block is idle. The block then makes one recoding step per clock cycle, one step for each multiplier bit. It signals completion with a one-cycle `done` pulse.

The working state is one 2N+1 bit shift register. The upper N bits are the running partial product and start at zero. The lower N bits start as the multiplier. One extra bit below the lower half holds the multiplier bit that was most recently shifted out, and it starts at zero.

Each step looks at the lowest multiplier bit together with that previous bit and chooses one action:
- pair 10 (start of a run of ones): subtract the multiplicand from the upper half;
- pair 01 (end of a run of ones): add the multiplicand to the upper half;
- pair 00 or 11: no arithmetic.

After the chosen action, the whole register shifts right by one position, and the sign of the new upper half is copied into the top bit. Because the register shifts arithmetically, signed operands need no negation before or after the multiply.

The adder/subtractor is one bit wider than an operand. This lets the shift copy the true sign even when the multiplicand is the most negative value.

Top module: `booth_seq_mul`

## Requirements
- R1: After reset `busy` and `done` are 0 and `product` is all zeros.
- R2: A `start` pulse while `busy` is 0 loads the operands, and `busy` is 1 from the next cycle until the operation completes.
- R3: On completion `product` equals the signed product of `multiplicand` and `multiplier` as a 2N-bit two's-complement value. This holds for every combination of operand signs, including zero and minus one.
- R4: The result is correct when either operand, or both, is the most negative value -2^(N-1). For example, with N=8, -128 times -128 gives 16'h4000.
- R5: `done` is 1 for exactly one cycle. That cycle is N clock edges after the edge that accepted `start`, and `busy` is 0 in it.
- R6: A `start` pulse while `busy` is 1 is ignored: the running operation keeps its operands and timing.
- R7: Operands are captured when `start` is accepted. Changing `multiplicand` or `multiplier` afterwards does not alter the result.
- R8: While idle with `start` low, `product` holds its last value.
- R9: A `start` pulse in the same cycle as `done` is accepted and begins a new operation.
- R10: With N=5, the multiplicand 5 (5'b00101) times the multiplier -3 (5'b11101) gives 10'b1111110001, which is -15.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request; accepted only while idle |
| multiplicand | input | N | Signed multiplicand, sampled on an accepted start |
| multiplier | input | N | Signed multiplier, sampled on an accepted start |
| busy | output | 1 | High while recoding steps are running |
| done | output | 1 | One-cycle completion pulse |
| product | output | 2N | Signed product; valid from the done cycle until the next accepted start |

## Verification
The completion pulse of one operation and the acceptance of the next request can fall in the same cycle. The bench provokes this by raising `start`, with fresh operands, in the very cycle where it sees `done`.

It then judges two things:
- the new operation is running: `busy` is high one cycle later and `done` has dropped;
- the second result arrives N cycles later with its own correct product, unaffected by the first operation's final step.

A second overlap is a request that arrives while a step is in flight. The bench judges it by an unchanged result and an unchanged latency.

// File: rtl/booth_mul_pkg.sv
package booth_mul_pkg;

   typedef enum logic [1:0] {
      STEP_HOLD = 2'd0,
      STEP_ADD  = 2'd1,
      STEP_SUB  = 2'd2
   } step_op_e;

   typedef enum logic {
      PH_IDLE = 1'b0,
      PH_RUN  = 1'b1
   } phase_e;

endpackage

// File: rtl/booth_recoder.sv
module booth_recoder
   import booth_mul_pkg::*;
(
   input  logic     cur_bit,
   input  logic     prev_bit,
   output step_op_e op
);

   always_comb begin
      unique case ({cur_bit, prev_bit})
         2'b10:   op = STEP_SUB;
         2'b01:   op = STEP_ADD;
         default: op = STEP_HOLD;
      endcase
   end

endmodule

// File: rtl/booth_step.sv
module booth_step
   import booth_mul_pkg::*;
#(
   parameter int unsigned N             = 32,
   parameter bit          SUB_BY_INVERT = 1'b1
) (
   input  logic [N-1:0] acc_hi,
   input  logic [N-1:0] acc_lo,
   input  logic [N-1:0] mcand,
   input  step_op_e     op,
   output logic [N-1:0] nxt_hi,
   output logic [N-1:0] nxt_lo,
   output logic         nxt_prev
);

   localparam int unsigned EW = N + 1;

   logic [EW-1:0] ext_acc;
   logic [EW-1:0] ext_m;
   logic [EW-1:0] sum;

   assign ext_acc = {acc_hi[N-1], acc_hi};
   assign ext_m   = {mcand[N-1], mcand};

   generate
      if (SUB_BY_INVERT) begin : g_shared_adder
         logic [EW-1:0] operand;
         logic [EW-1:0] cin;
         always_comb begin
            unique case (op)
               STEP_ADD: operand = ext_m;
               STEP_SUB: operand = ~ext_m;
               default:  operand = '0;
            endcase
            cin = {{(EW-1){1'b0}}, (op == STEP_SUB)};
         end
         assign sum = ext_acc + operand + cin;
      end else begin : g_split_addsub
         logic [EW-1:0] plus;
         logic [EW-1:0] minus;
         assign plus  = ext_acc + ext_m;
         assign minus = ext_acc - ext_m;
         always_comb begin
            unique case (op)
               STEP_ADD: sum = plus;
               STEP_SUB: sum = minus;
               default:  sum = ext_acc;
            endcase
         end
      end
   endgenerate

   assign nxt_hi   = sum[EW-1:1];
   assign nxt_lo   = {sum[0], acc_lo[N-1:1]};
   assign nxt_prev = acc_lo[0];

endmodule

// File: rtl/booth_ctrl.sv
module booth_ctrl
   import booth_mul_pkg::*;
#(
   parameter int unsigned N = 32
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   output logic busy,
   output logic done,
   output logic load,
   output logic step
);

   localparam int unsigned CW = (N > 2) ? $clog2(N) : 1;
   localparam logic [CW-1:0] LAST = CW'(N - 1);

   phase_e        phase;
   logic [CW-1:0] count;
   logic          last_step;

   assign busy      = (phase == PH_RUN);
   assign load      = start && !busy;
   assign step      = busy;
   assign last_step = busy && (count == LAST);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase <= PH_IDLE;
         count <= '0;
         done  <= 1'b0;
      end else begin
         done <= 1'b0;
         if (load) begin
            phase <= PH_RUN;
            count <= '0;
         end else if (busy) begin
            if (last_step) begin
               phase <= PH_IDLE;
               count <= '0;
               done  <= 1'b1;
            end else begin
               count <= count + 1'b1;
            end
         end
      end
   end

   a_r5_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !busy);

   a_r5_done_single: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   a_r2_start_runs: assert property (@(posedge clk) disable iff (!rst_n)
      (start && !busy) |=> busy);

   a_r6_run_holds: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !done && count != LAST) |=> (busy && !done));

   a_r5_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
      count <= LAST);

endmodule

// File: rtl/booth_seq_mul.sv
module booth_seq_mul
   import booth_mul_pkg::*;
#(
   parameter int unsigned N             = 32,
   parameter bit          SUB_BY_INVERT = 1'b1
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           start,
   input  logic [N-1:0]   multiplicand,
   input  logic [N-1:0]   multiplier,
   output logic           busy,
   output logic           done,
   output logic [2*N-1:0] product
);

   generate
      if (N < 2) begin : g_bad_width
         $error("booth_seq_mul: N must be at least 2");
      end
   endgenerate

   logic [N-1:0] acc_hi;
   logic [N-1:0] acc_lo;
   logic         acc_prev;
   logic [N-1:0] mcand_q;

   logic [N-1:0] nxt_hi;
   logic [N-1:0] nxt_lo;
   logic         nxt_prev;
   step_op_e     op;
   logic         load;
   logic         step;

   booth_ctrl #(.N(N)) u_ctrl (
      .clk   (clk),
      .rst_n (rst_n),
      .start (start),
      .busy  (busy),
      .done  (done),
      .load  (load),
      .step  (step)
   );

   booth_recoder u_recode (
      .cur_bit  (acc_lo[0]),
      .prev_bit (acc_prev),
      .op       (op)
   );

   booth_step #(.N(N), .SUB_BY_INVERT(SUB_BY_INVERT)) u_step (
      .acc_hi   (acc_hi),
      .acc_lo   (acc_lo),
      .mcand    (mcand_q),
      .op       (op),
      .nxt_hi   (nxt_hi),
      .nxt_lo   (nxt_lo),
      .nxt_prev (nxt_prev)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         acc_hi   <= '0;
         acc_lo   <= '0;
         acc_prev <= 1'b0;
         mcand_q  <= '0;
      end else if (load) begin
         acc_hi   <= '0;
         acc_lo   <= multiplier;
         acc_prev <= 1'b0;
         mcand_q  <= multiplicand;
      end else if (step) begin
         acc_hi   <= nxt_hi;
         acc_lo   <= nxt_lo;
         acc_prev <= nxt_prev;
      end
   end

   assign product = {acc_hi, acc_lo};

   a_r8_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && !start) |=> $stable(product));

   a_r7_mcand_kept: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !done) |=> $stable(mcand_q));

endmodule

// File: tb/booth_seq_mul_test.sv
module booth_seq_mul_test;

   localparam int CLK_PERIOD = 10;
   localparam int W = 8;
   localparam int NV = 12;
   localparam logic [2*W-1:0] VEC [0:NV-1] = '{
      16'h05FD, 16'h0706, 16'hF906, 16'hFFFF,
      16'h0037, 16'h7F7F, 16'h8001, 16'h8080,
      16'h807F, 16'h55AA, 16'h0180, 16'hC3F0
   };

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic start = 1'b0;
   logic [W-1:0] mcand = '0;
   logic [W-1:0] mplier = '0;
   logic busy, done;
   logic [2*W-1:0] product;

   logic start5 = 1'b0;
   logic [4:0] mcand5 = '0;
   logic [4:0] mplier5 = '0;
   logic busy5, done5;
   logic [9:0] product5;

   int checks = 0;
   int errors = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   booth_seq_mul #(.N(W)) uut (
      .clk(clk), .rst_n(rst_n), .start(start),
      .multiplicand(mcand), .multiplier(mplier),
      .busy(busy), .done(done), .product(product)
   );

   booth_seq_mul #(.N(5), .SUB_BY_INVERT(1'b0)) uut5 (
      .clk(clk), .rst_n(rst_n), .start(start5),
      .multiplicand(mcand5), .multiplier(mplier5),
      .busy(busy5), .done(done5), .product(product5)
   );

   function automatic logic [2*W-1:0] ref_mul(input logic [W-1:0] a, input logic [W-1:0] b);
      logic signed [2*W-1:0] ea, eb;
      ea = $signed({{W{a[W-1]}}, a});
      eb = $signed({{W{b[W-1]}}, b});
      return 16'(ea * eb);
   endfunction

   task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // called at a negedge just after the accepting edge; returns negedges until done
   task automatic wait_done(output int lat);
      lat = 0;
      while (!done && lat < 4*W) begin
         @(negedge clk);
         lat++;
      end
   endtask

   task automatic run_op(input logic [W-1:0] a, input logic [W-1:0] b, input string req);
      int lat;
      @(negedge clk);
      mcand = a; mplier = b; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      mcand = ~a; mplier = b ^ 8'h5A;   // R7 operands change after capture
      check(busy == 1'b1, "R2 busy after start", 64'(busy), 64'd1);
      wait_done(lat);
      check(lat == W, "R5 latency", 64'(lat), 64'(W));
      check(busy == 1'b0, "R5 busy low with done", 64'(busy), 64'd0);
      check(product == ref_mul(a, b), req, 64'(product), 64'(ref_mul(a, b)));
      @(negedge clk);
      check(done == 1'b0, "R5 done one cycle", 64'(done), 64'd0);
   endtask

   initial begin
      #(CLK_PERIOD * 100000);
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      int lat;
      logic [2*W-1:0] held;
      repeat (3) @(negedge clk);
      check(busy == 1'b0 && done == 1'b0, "R1 reset flags", {62'd0, busy, done}, 64'd0);
      check(product == '0, "R1 reset product", 64'(product), 64'd0);
      rst_n = 1'b1;
      @(negedge clk);

      // R3 R4 R7 vector walk
      for (int i = 0; i < NV; i++) begin
         run_op(VEC[i][2*W-1:W], VEC[i][W-1:0],
                (VEC[i][2*W-1] || VEC[i][W-1:0] == 8'h80) ? "R4 R3 product" : "R3 product");
      end

      // R8 hold while idle with changing inputs
      held = product;
      mcand = 8'h11; mplier = 8'h22;
      repeat (5) @(negedge clk);
      check(product == held, "R8 idle hold", 64'(product), 64'(held));

      // R6 start while busy is ignored
      @(negedge clk);
      mcand = 8'hF3; mplier = 8'h19; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      repeat (2) @(negedge clk);
      mcand = 8'h7F; mplier = 8'h7F; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      lat = 3;
      while (!done && lat < 4*W) begin
         @(negedge clk);
         lat++;
      end
      check(lat == W, "R6 latency unchanged", 64'(lat), 64'(W));
      check(product == ref_mul(8'hF3, 8'h19), "R6 result unchanged", 64'(product), 64'(ref_mul(8'hF3, 8'h19)));

      // R9 start in the done cycle
      mcand = 8'h9C; mplier = 8'hE7; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      check(busy == 1'b1 && done == 1'b0, "R9 restart accepted", {62'd0, busy, done}, 64'd2);
      wait_done(lat);
      check(lat == W, "R9 second latency", 64'(lat), 64'(W));
      check(product == ref_mul(8'h9C, 8'hE7), "R9 second product", 64'(product), 64'(ref_mul(8'h9C, 8'hE7)));

      // R10 five-bit example
      @(negedge clk);
      mcand5 = 5'b00101; mplier5 = 5'b11101; start5 = 1'b1;
      @(negedge clk);
      start5 = 1'b0;
      lat = 0;
      while (!done5 && lat < 40) begin
         @(negedge clk);
         lat++;
      end
      check(lat == 5, "R10 latency", 64'(lat), 64'd5);
      check(product5 == 10'b1111110001, "R10 five-bit product", 64'(product5), 64'h3F1);

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule